// File: doc/BRIEF.md
# Per-Lane Scratch Address Swizzler

This block turns one private-memory access of a 64-lane wavefront into a stream of per-lane byte addresses. On a start pulse it samples a 64-bit scratch base, a 32-bit instruction offset, an optional scalar offset (gated by a selector), per-lane vector offsets with an enable, the element sizes of the load and store forms, and the execution mask. It then steps through the lanes in ascending order, one lane per cycle, and presents the address of every active lane.

The layout interleaves lanes so that the dwords of one lane sit 256 bytes apart, while neighbouring lanes are packed at element-size spacing inside each 256-byte row. When all lanes have been visited, a one-cycle done pulse follows. The surrounding pipeline supplies the base and consumes the addresses; the block issues no memory requests itself.

Top module: `scratch_swizzle_gen`

## Requirements
- R1: While reset is low and in the first cycle after it, busy, addr_valid, addr_lane, lane_addr and done are all zero.
- R2: For an active lane L with combined 32-bit offset O and element size S bytes, lane_addr = base + (O / 4) * 256 + (O % 4) + L * S, computed in 64 bits. The size codes are log2 of the byte count: 0→1, 1→2, 2→4, 3→8, 4→16.
- R3: When voff_en is 1, lane L's 32-bit slice lane_voff[32L+31:32L] is added to the offset. When voff_en is 0, the slices have no effect on any address.
- R4: A saddr_sel value of 7'h7F adds nothing. Any other selector value adds saddr_data to the offset.
- R5: When is_store is 0, the element size is taken from dst_size. When is_store is 1, it is taken from data_size.
- R6: Only lanes whose exec_mask bit is 1 produce an addr_valid cycle. With an empty mask, no address appears at all.
- R7: If start is sampled at clock edge E0 while the block is idle, lane L's result (addr_valid with addr_lane = L) is visible after edge E0+1+L. Lanes are visited in strictly ascending order.
- R8: done is high for exactly one cycle, after edge E0+65 (one cycle after lane 63's slot), whatever the mask is.
- R9: A start pulse while busy is ignored. The running access continues with its sampled operands, and no extra addresses or done pulses appear.
- R10: The offset sum (instruction + scalar + vector) wraps modulo 2^32 before swizzling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an access; sampled only when idle |
| scratch_base | input | 64 | Scratch base address |
| inst_offset | input | 32 | Instruction immediate offset |
| lane_voff | input | 2048 | Per-lane vector offsets, 32 bits per lane, lane 0 lowest |
| voff_en | input | 1 | Add per-lane vector offsets |
| saddr_sel | input | 7 | Scalar offset selector; 7'h7F means none |
| saddr_data | input | 32 | Scalar offset value |
| is_store | input | 1 | 1 = store (use data_size), 0 = load (use dst_size) |
| dst_size | input | 3 | Load destination element size code (log2 bytes) |
| data_size | input | 3 | Store data element size code (log2 bytes) |
| exec_mask | input | 64 | Lane execution mask |
| busy | output | 1 | Lane walk in progress |
| addr_valid | output | 1 | lane_addr holds an active lane's address |
| addr_lane | output | 6 | Lane index of the current address |
| lane_addr | output | 64 | Swizzled per-lane byte address |
| done | output | 1 | One-cycle pulse after the last lane slot |

## Verification
The bench builds the block with its default parameters: 64 lanes, 32-bit offsets, a 64-bit base and a 7-bit selector. At these values, 16-byte elements make lane spacing run across several 256-byte rows, so lane and dword terms overlap in the sum. Lane 63 is reached, which tests the done timing after a full walk. An offset near 2^32 tests the 32-bit wrap before the 64-bit base add.

// File: rtl/scr_swz_pkg.sv
// Package: shared constants, types and the swizzle arithmetic for the
// scratch address swizzler. Assumes byte addressing and dword rows.
package scr_swz_pkg;
    typedef logic [2:0] esz_code_t;          // log2 of element size in bytes
    localparam int DWORD_BYTES = 4;

    // Row-interleaved offset: dword index times row bytes plus byte-in-dword
    function automatic logic [63:0] swz_offset(input logic [31:0] off,
                                               input int unsigned row_bytes);
        return (64'(off) / DWORD_BYTES) * 64'(row_bytes)
             + 64'(off % DWORD_BYTES);
    endfunction
endpackage

// File: rtl/scr_lane_seq.sv
// Lane sequencer: accepts a start only while idle, then walks the lane index
// upward one per cycle and flags the final lane. Assumes LANES >= 2.
module scr_lane_seq #(
    parameter int LANES  = 64,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              accept,
    output logic              busy,
    output logic [LANE_W-1:0] lane,
    output logic              last
);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    // Start is honoured only from idle
    always_comb accept = start && !busy;
    // Final lane marker
    always_comb last = busy && (lane == LAST_LANE);

    // Busy flag and lane counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            lane <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            lane <= '0;
        end else if (busy) begin
            if (lane == LAST_LANE) busy <= 1'b0;
            else                   lane <= lane + LANE_W'(1);
        end
    end
endmodule

// File: rtl/scr_swz_calc.sv
// Swizzle calculator (combinational): adds the optional vector offset to the
// pre-combined offset with 32-bit wrap, interleaves it by rows of
// 4*LANES bytes, adds lane spacing by element size and the base.
module scr_swz_calc
    import scr_swz_pkg::*;
#(
    parameter int LANES  = 64,
    parameter int OFF_W  = 32,
    parameter int ADDR_W = 64,
    localparam int LANE_W = $clog2(LANES),
    localparam int ROW_BYTES = DWORD_BYTES * LANES
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  off,
    input  logic [OFF_W-1:0]  voff,
    input  logic              voff_en,
    input  logic [LANE_W-1:0] lane,
    input  esz_code_t         esz,
    output logic [ADDR_W-1:0] addr
);
    logic [OFF_W-1:0]  lane_off;
    logic [ADDR_W-1:0] lane_step;

    // Combined per-lane offset, wrapping at the offset width
    always_comb lane_off = off + (voff_en ? voff : '0);
    // Lane spacing of one element
    always_comb lane_step = ADDR_W'(lane) << esz;
    // Final address
    always_comb addr = base + ADDR_W'(swz_offset(32'(lane_off), ROW_BYTES)) + lane_step;
endmodule

// File: rtl/scr_addr_out.sv
// Output stage: registers the address of each active lane and raises a
// one-cycle done one cycle after the final lane slot.
module scr_addr_out #(
    parameter int LANES  = 64,
    parameter int ADDR_W = 64,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_valid,
    input  logic              step_last,
    input  logic [LANE_W-1:0] step_lane,
    input  logic [ADDR_W-1:0] step_addr,
    output logic              addr_valid,
    output logic [LANE_W-1:0] addr_lane,
    output logic [ADDR_W-1:0] lane_addr,
    output logic              done
);
    logic last_q;

    // Address register, loaded only for active lanes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            addr_lane  <= '0;
            lane_addr  <= '0;
        end else begin
            addr_valid <= step_valid;
            if (step_valid) begin
                addr_lane <= step_lane;
                lane_addr <= step_addr;
            end
        end
    end

    // Done pulse trails the final lane slot by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            last_q <= step_last;
            done   <= last_q;
        end
    end
endmodule

// File: rtl/scratch_swizzle_gen.sv
// Top: samples the access operands on an accepted start, walks all lanes,
// and emits swizzled scratch addresses for the active ones.
// Assumes size codes 0..4 (1..16 bytes); operands are held internally.
module scratch_swizzle_gen
    import scr_swz_pkg::*;
#(
    parameter int LANES    = 64,
    parameter int OFF_W    = 32,
    parameter int ADDR_W   = 64,
    parameter int SEL_W    = 7,
    parameter logic [SEL_W-1:0] NO_SADDR = 7'h7F,
    localparam int LANE_W  = $clog2(LANES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [ADDR_W-1:0]      scratch_base,
    input  logic [OFF_W-1:0]       inst_offset,
    input  logic [LANES*OFF_W-1:0] lane_voff,
    input  logic                   voff_en,
    input  logic [SEL_W-1:0]       saddr_sel,
    input  logic [OFF_W-1:0]       saddr_data,
    input  logic                   is_store,
    input  logic [2:0]             dst_size,
    input  logic [2:0]             data_size,
    input  logic [LANES-1:0]       exec_mask,
    output logic                   busy,
    output logic                   addr_valid,
    output logic [LANE_W-1:0]      addr_lane,
    output logic [ADDR_W-1:0]      lane_addr,
    output logic                   done
);
    logic                   accept, seq_busy, seq_last;
    logic [LANE_W-1:0]      seq_lane;
    logic [ADDR_W-1:0]      base_q, calc_addr;
    logic [OFF_W-1:0]       off_q;
    logic [LANES*OFF_W-1:0] voff_q;
    logic                   voff_en_q;
    esz_code_t              esz_q;
    logic [LANES-1:0]       mask_q;

    scr_lane_seq #(.LANES(LANES)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
        .busy(seq_busy), .lane(seq_lane), .last(seq_last)
    );

    // Operand capture on an accepted start; scalar offset folded in here
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            off_q     <= '0;
            voff_q    <= '0;
            voff_en_q <= 1'b0;
            esz_q     <= '0;
            mask_q    <= '0;
        end else if (accept) begin
            base_q    <= scratch_base;
            off_q     <= inst_offset + ((saddr_sel != NO_SADDR) ? saddr_data : '0);
            voff_q    <= lane_voff;
            voff_en_q <= voff_en;
            esz_q     <= is_store ? data_size : dst_size;
            mask_q    <= exec_mask;
        end
    end

    scr_swz_calc #(.LANES(LANES), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) calc_i (
        .base(base_q), .off(off_q),
        .voff(voff_q[seq_lane*OFF_W +: OFF_W]), .voff_en(voff_en_q),
        .lane(seq_lane), .esz(esz_q), .addr(calc_addr)
    );

    scr_addr_out #(.LANES(LANES), .ADDR_W(ADDR_W)) out_i (
        .clk(clk), .rst_n(rst_n),
        .step_valid(seq_busy && mask_q[seq_lane]), .step_last(seq_last),
        .step_lane(seq_lane), .step_addr(calc_addr),
        .addr_valid(addr_valid), .addr_lane(addr_lane),
        .lane_addr(lane_addr), .done(done)
    );

    // Busy reflects the lane walk
    always_comb busy = seq_busy;
endmodule

// File: rtl/scr_swz_chk.sv
// Checker: temporal properties of the lane walk and output stage.
module scr_swz_chk #(
    parameter int LANES  = 64,
    localparam int LANE_W = $clog2(LANES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic [LANE_W-1:0] lane,
    input logic [LANES-1:0]  mask_q,
    input logic              addr_valid,
    input logic [LANE_W-1:0] addr_lane,
    input logic              done
);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    a_r7_lane_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> lane == $past(lane) + LANE_W'(1));

    a_r7_valid_follows_walk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> $past(busy));

    a_r6_only_masked_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> mask_q[addr_lane]);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_after_addrs: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !addr_valid);

    a_r9_start_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && lane != LAST_LANE |=> busy && lane == $past(lane) + LANE_W'(1));
endmodule

bind scratch_swizzle_gen scr_swz_chk #(.LANES(LANES)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(seq_busy), .lane(seq_lane),
    .mask_q(mask_q), .addr_valid(addr_valid), .addr_lane(addr_lane), .done(done)
);

// File: tb/scratch_swizzle_gen_tb_top.sv
// Scoreboard bench: driver pushes expected lane/address/cycle items, a
// negedge monitor pops and compares them against the outputs.
module scratch_swizzle_gen_tb_top;
    localparam int LANES = 64;
    localparam int OFF_W = 32;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic [63:0]            scratch_base = '0;
    logic [31:0]            inst_offset = '0;
    logic [LANES*OFF_W-1:0] lane_voff = '0;
    logic                   voff_en = 1'b0;
    logic [6:0]             saddr_sel = 7'h7F;
    logic [31:0]            saddr_data = '0;
    logic                   is_store = 1'b0;
    logic [2:0]             dst_size = '0;
    logic [2:0]             data_size = '0;
    logic [LANES-1:0]       exec_mask = '0;
    logic                   busy, addr_valid, done;
    logic [5:0]             addr_lane;
    logic [63:0]            lane_addr;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int done_cnt = 0;
    int valid_cnt = 0;
    int exp_done_cyc = -1;
    string cur_tag = "R2";

    int          q_lane[$];
    logic [63:0] q_addr[$];
    int          q_cyc[$];

    scratch_swizzle_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .scratch_base(scratch_base),
        .inst_offset(inst_offset), .lane_voff(lane_voff), .voff_en(voff_en),
        .saddr_sel(saddr_sel), .saddr_data(saddr_data), .is_store(is_store),
        .dst_size(dst_size), .data_size(data_size), .exec_mask(exec_mask),
        .busy(busy), .addr_valid(addr_valid), .addr_lane(addr_lane),
        .lane_addr(lane_addr), .done(done)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected address from the requirement formula
    function automatic logic [63:0] model(input logic [63:0] base, input logic [31:0] off,
                                          input int lane, input int code);
        return base + (64'(off) / 4) * 256 + 64'(off % 4) + 64'(lane) * (64'(1) << code);
    endfunction

    // Monitor: pops and compares as results appear
    always @(negedge clk) begin
        if (rst_n && addr_valid) begin
            valid_cnt++;
            if (q_lane.size() == 0) begin
                check(1'b0, "R6", "unexpected address lane", 64'(addr_lane), 64'hFFFF);
            end else begin
                int el, ec;
                logic [63:0] ea;
                el = q_lane.pop_front(); ea = q_addr.pop_front(); ec = q_cyc.pop_front();
                check(addr_lane == 6'(el), "R7", "lane order", 64'(addr_lane), 64'(el));
                check(cyc == ec, "R7", "lane cycle", 64'(cyc), 64'(ec));
                check(lane_addr == ea, cur_tag, "address", lane_addr, ea);
            end
        end
        if (rst_n && done) begin
            done_cnt++;
            check(cyc == exp_done_cyc, "R8", "done cycle", 64'(cyc), 64'(exp_done_cyc));
        end
    end

    // Driver: launches one access and pushes its expectations
    task automatic run(input string tag, input logic [63:0] base, input logic [31:0] ioff,
                       input bit ven, input logic [6:0] sel, input logic [31:0] sdat,
                       input bit st, input logic [2:0] dsz, input logic [2:0] ssz,
                       input logic [LANES-1:0] mask, input bit intrude);
        int n, d0, code;
        logic [31:0] o;
        cur_tag = tag;
        d0 = done_cnt; valid_cnt = 0;
        @(negedge clk);
        scratch_base = base; inst_offset = ioff; voff_en = ven; saddr_sel = sel;
        saddr_data = sdat; is_store = st; dst_size = dsz; data_size = ssz;
        exec_mask = mask; start = 1'b1;
        @(posedge clk); #1;
        n = cyc;
        code = st ? int'(ssz) : int'(dsz);
        for (int l = 0; l < LANES; l++) begin
            if (mask[l]) begin
                o = ioff + (ven ? lane_voff[l*32 +: 32] : 32'd0) + ((sel != 7'h7F) ? sdat : 32'd0);
                q_lane.push_back(l); q_addr.push_back(model(base, o, l, code));
                q_cyc.push_back(n + 1 + l);
            end
        end
        exp_done_cyc = n + 65;
        @(negedge clk); start = 1'b0;
        // Altered operands presented mid-walk must change nothing (R9)
        scratch_base = ~base; inst_offset = ioff + 32'h40; exec_mask = ~mask;
        if (intrude) begin
            repeat (10) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (cyc < n + 68) @(negedge clk);
        check(done_cnt == d0 + 1, intrude ? "R9" : "R8", "done pulses", 64'(done_cnt - d0), 64'd1);
        check(valid_cnt == $countones(mask), intrude ? "R9" : "R6", "active lane count",
              64'(valid_cnt), 64'($countones(mask)));
        check(q_lane.size() == 0, "R6", "missing lanes", 64'(q_lane.size()), 64'd0);
        check(busy == 1'b0, "R9", "idle after walk", 64'(busy), 64'd0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(busy == 0, "R1", "busy in reset", 64'(busy), 0);
        check(addr_valid == 0 && done == 0, "R1", "valid/done in reset", 64'({addr_valid, done}), 0);
        check(lane_addr == 0 && addr_lane == 0, "R1", "addr in reset", lane_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && addr_valid == 0 && done == 0, "R1", "first cycle after reset",
              64'({busy, addr_valid, done}), 0);

        // R2: full mask, 4-byte elements, plain offset
        run("R2", 64'h0000_1000_0000_0000, 32'h0000_0123, 0, 7'h7F, 32'h0, 0, 3'd2, 3'd0, '1, 0);
        // R2: 16-byte elements, spacing crosses rows
        run("R2", 64'h0000_0000_8000_0000, 32'h0000_0007, 0, 7'h7F, 32'h0, 0, 3'd4, 3'd0, '1, 0);
        // R3: vector offsets enabled, 1-byte elements
        for (int l = 0; l < LANES; l++) lane_voff[l*32 +: 32] = 32'(l * 37 + 5);
        run("R3", 64'h0000_0000_0001_0000, 32'h10, 1, 7'h7F, 32'h0, 0, 3'd0, 3'd0, '1, 0);
        // R3: vector offsets present but disabled
        run("R3", 64'h0000_0000_0001_0000, 32'h10, 0, 7'h7F, 32'h0, 0, 3'd0, 3'd0, '1, 0);
        // R4: scalar offset selected, and the none value with data present
        run("R4", 64'h0000_0000_0002_0000, 32'h3, 0, 7'h05, 32'h0000_0401, 0, 3'd3, 3'd0, '1, 0);
        run("R4", 64'h0000_0000_0002_0000, 32'h3, 0, 7'h7F, 32'h0000_0401, 0, 3'd3, 3'd0, '1, 0);
        // R5: store takes data size, load takes destination size
        run("R5", 64'h0000_0000_0003_0000, 32'h20, 0, 7'h7F, 32'h0, 1, 3'd0, 3'd3, '1, 0);
        run("R5", 64'h0000_0000_0003_0000, 32'h20, 0, 7'h7F, 32'h0, 0, 3'd1, 3'd4, '1, 0);
        // R6: sparse mask, and empty mask
        run("R6", 64'h0000_0000_0004_0000, 32'h8, 0, 7'h7F, 32'h0, 0, 3'd1, 3'd0,
            64'hA5A5_0F0F_8000_0001, 0);
        run("R6", 64'h0000_0000_0004_0000, 32'h8, 0, 7'h7F, 32'h0, 0, 3'd1, 3'd0, '0, 0);
        // R10: offset sum wraps at 32 bits
        run("R10", 64'h0000_0001_0000_0000, 32'hFFFF_FFFE, 1, 7'h01, 32'h0000_0004, 0, 3'd2, 3'd0,
            64'hFFFF_0000_FFFF_0001, 0);
        // R9: start while busy is ignored
        run("R9", 64'h0000_0000_0005_0000, 32'h44, 0, 7'h7F, 32'h0, 0, 3'd2, 3'd0,
            64'h0F0F_F0F0_1234_5678, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule